// File: doc/BRIEF.md
# DMA Channel Status and Control Register Bank

This block is the shared register bank of a multi-channel, descriptor-driven DMA engine. Software reaches it over a simple 32-bit register bus with a write strobe, a read strobe and a byte address. It holds four registers: a global control word with two burst enables, a completion word (per-channel completion flags in the low half, per-channel interrupt enables in the high half), an error word (per-channel error flags in the low half, per-channel error kind in the high half), and a channel control word (per-channel freeze bits in the low half, per-channel reset requests in the high half).

The channel engines pulse completion, termination and bus-error events into the bank. The bank combines flags and enables into one interrupt line per channel, and drives per-channel freeze levels and one-cycle reset pulses. Each register answers at three addresses. The base address replaces the register. Base+4 ORs the written ones in. Base+8 clears the bits written as one. Because of these aliases, software can touch one channel's bit without a read-modify-write race against the engines or against other channels.

Top module: `dma_chan_regbank`

## Requirements
- R1: After synchronous reset every register reads zero, and every interrupt, freeze, reset-pulse and burst output is low.
- R2: Address bits [5:4] select the register: 0 control, 1 completion, 2 error, 3 channel control. With address bits [3:2] = 0, a write replaces every writable bit of the selected register. In the control word only bits 28 and 29 are writable; all its other bits read zero.
- R3: A write with address bits [3:2] = 1 sets the bits written as one and leaves every other bit unchanged.
- R4: A write with address bits [3:2] = 2 clears the bits written as one and leaves every other bit unchanged.
- R5: A completion event on channel n sets bit n of the completion word.
- R6: A termination event on channel n without a completion that cycle sets error bit n and clears bit 16+n. A termination that arrives together with a completion on the same channel leaves the error word unchanged.
- R7: A bus-error event on channel n sets both error bit n and bit 16+n.
- R8: When a hardware event and a clear-alias write hit the same flag in the same cycle, the flag ends up set. Other bits cleared by that write still clear.
- R9: Interrupt line n is registered and equals (completion bit n AND completion bit 16+n) OR error bit n, one cycle after the register state.
- R10: Freeze output n follows bit n of the channel control word. Clearing that bit releases the channel.
- R11: A plain or set-alias write with a one in channel control bit 16+n produces exactly one reset pulse on channel n, high during the second cycle after the write edge. The request bit then clears by itself, and a clear-alias write produces no pulse.
- R12: A read strobe loads the read-data register at the clock edge with the selected register. Any of the three alias addresses reads the same register. Addresses with bits [7:6] non-zero, or with bits [3:2] = 3, read zero.
- R13: Burst enable follows control bit 28 and 8-beat burst enable follows control bit 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW (8) | Byte address: [5:4] register, [3:2] alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_done | input | NCH (16) | Per-channel completion event pulses |
| evt_term | input | NCH (16) | Per-channel termination event pulses |
| evt_buserr | input | NCH (16) | Per-channel bus-error event pulses |
| chan_irq | output | NCH (16) | Per-channel interrupt lines |
| chan_freeze | output | NCH (16) | Per-channel freeze levels |
| chan_reset | output | NCH (16) | Per-channel one-cycle reset pulses |
| burst_en | output | 1 | Burst enable |
| burst8_en | output | 1 | 8-beat burst enable |

## Verification
The alias logic is tried with plain, set and clear writes on the same register, each starting from a mixed bit pattern. This shows whether the unaddressed bits are preserved and whether only the written ones act. The event inputs are driven alone, in combination (termination with completion), and against a same-cycle clear write. This separates the error classification from the set-versus-clear priority. Reset requests are written through each alias and the pulse is sampled cycle by cycle, which catches a pulse that is early, late, or too long.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
  localparam int DW   = 32;
  localparam int HALF = 16;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PLAIN = 2'd1,
    OP_SET   = 2'd2,
    OP_CLR   = 2'd3
  } wr_op_e;

  // software result of one access on a register value
  function automatic logic [DW-1:0] sw_next(wr_op_e op, logic [DW-1:0] cur, logic [DW-1:0] wd);
    case (op)
      OP_PLAIN: return wd;
      OP_SET:   return cur | wd;
      OP_CLR:   return cur & ~wd;
      default:  return cur;
    endcase
  endfunction

  // address bits [3:2] to access kind
  function automatic wr_op_e alias_op(logic [1:0] a);
    case (a)
      2'd0:    return OP_PLAIN;
      2'd1:    return OP_SET;
      2'd2:    return OP_CLR;
      default: return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dmab_alias_reg.sv
module dmab_alias_reg
  import dmab_pkg::*;
#(
  parameter logic [DW-1:0] WMASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  wr_op_e        op,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_set,
  input  logic [DW-1:0] hw_clr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] sw_val;
  logic [DW-1:0] merged;
  logic [DW-1:0] nxt;

  always_comb begin
    sw_val = sw_next(op, q, wdata);
    merged = (q & ~WMASK) | (sw_val & WMASK);
    // hardware clear overrides software, hardware set overrides both
    nxt    = (merged & ~(hw_clr & WMASK)) | (hw_set & WMASK);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ((hw_set & WMASK) != '0) |=> ((q & $past(hw_set & WMASK)) == $past(hw_set & WMASK))); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NONE && hw_set == '0 && hw_clr == '0) |=> $stable(q)); // R2
endmodule

// File: rtl/dmab_rst_gen.sv
module dmab_rst_gen #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req_set,
  output logic [NCH-1:0] req_q,
  output logic [NCH-1:0] pulse_q
);
  // request lives one cycle, then becomes the pulse for one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= '0;
      pulse_q <= '0;
    end else begin
      req_q   <= req_set;
      pulse_q <= req_q;
    end
  end

  AST_REQ_SELF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (req_q != '0 && req_set == '0) |=> (req_q == '0)); // R11
endmodule

// File: rtl/dmab_irq_comb.sv
module dmab_irq_comb #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] done_flag,
  input  logic [NCH-1:0] done_en,
  input  logic [NCH-1:0] err_flag,
  output logic [NCH-1:0] irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= (done_flag & done_en) | err_flag;
  end
endmodule

// File: rtl/dma_chan_regbank.sv
module dma_chan_regbank
  import dmab_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int AW         = 8,
  parameter int BURST_BIT  = 28,
  parameter int BURST8_BIT = 29
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] evt_done,
  input  logic [NCH-1:0] evt_term,
  input  logic [NCH-1:0] evt_buserr,
  output logic [NCH-1:0] chan_irq,
  output logic [NCH-1:0] chan_freeze,
  output logic [NCH-1:0] chan_reset,
  output logic           burst_en,
  output logic           burst8_en
);
  localparam int NREG = 4;
  localparam logic [DW-1:0] CHM   = DW'((64'd1 << NCH) - 64'd1);
  localparam logic [DW-1:0] PAIRM = CHM | (CHM << HALF);
  localparam logic [DW-1:0] CTRLM = (DW'(1) << BURST_BIT) | (DW'(1) << BURST8_BIT);

  // ---------------- decode ----------------
  logic   hit;
  logic   alias_ok;
  wr_op_e aop;
  wr_op_e op_v [NREG];

  assign hit      = (bus_addr[AW-1:6] == '0);
  assign alias_ok = (bus_addr[3:2] != 2'b11);
  assign aop      = alias_op(bus_addr[3:2]);

  for (genvar r = 0; r < NREG; r++) begin : g_dec
    assign op_v[r] = (bus_wr && hit && bus_addr[5:4] == 2'(r)) ? aop : OP_NONE;
  end

  // ---------------- event mapping ----------------
  logic [NCH-1:0] err_hit;
  logic [NCH-1:0] term_only;
  logic [DW-1:0]  done_hw;
  logic [DW-1:0]  err_set;
  logic [DW-1:0]  err_clr;

  assign term_only = evt_term & ~evt_done & ~evt_buserr;
  assign err_hit   = evt_buserr | (evt_term & ~evt_done);
  assign done_hw   = DW'(evt_done);
  assign err_set   = DW'(err_hit) | (DW'(evt_buserr) << HALF);
  assign err_clr   = DW'(term_only) << HALF;

  // ---------------- registers ----------------
  logic [DW-1:0] ctrl_q, done_q, err_q, frz_q;

  dmab_alias_reg #(.WMASK(CTRLM)) u_ctrl (
    .clk(clk), .rst(rst), .op(op_v[0]), .wdata(bus_wdata),
    .hw_set('0), .hw_clr('0), .q(ctrl_q));

  dmab_alias_reg #(.WMASK(PAIRM)) u_done (
    .clk(clk), .rst(rst), .op(op_v[1]), .wdata(bus_wdata),
    .hw_set(done_hw), .hw_clr('0), .q(done_q));

  dmab_alias_reg #(.WMASK(PAIRM)) u_err (
    .clk(clk), .rst(rst), .op(op_v[2]), .wdata(bus_wdata),
    .hw_set(err_set), .hw_clr(err_clr), .q(err_q));

  dmab_alias_reg #(.WMASK(CHM)) u_frz (
    .clk(clk), .rst(rst), .op(op_v[3]), .wdata(bus_wdata),
    .hw_set('0), .hw_clr('0), .q(frz_q));

  // ---------------- reset requests ----------------
  logic [NCH-1:0] rst_req_set;
  logic [NCH-1:0] rst_req_q;

  assign rst_req_set = (op_v[3] == OP_PLAIN || op_v[3] == OP_SET) ? bus_wdata[HALF +: NCH] : '0;

  dmab_rst_gen #(.NCH(NCH)) u_rst (
    .clk(clk), .rst(rst), .req_set(rst_req_set),
    .req_q(rst_req_q), .pulse_q(chan_reset));

  // ---------------- interrupts ----------------
  dmab_irq_comb #(.NCH(NCH)) u_irq (
    .clk(clk), .rst(rst),
    .done_flag(done_q[NCH-1:0]), .done_en(done_q[HALF +: NCH]),
    .err_flag(err_q[NCH-1:0]), .irq_q(chan_irq));

  // ---------------- read path ----------------
  logic [DW-1:0] rd_val;
  logic [DW-1:0] rdata_q;

  always_comb begin
    rd_val = '0;
    if (hit && alias_ok) begin
      case (bus_addr[5:4])
        2'd0:    rd_val = ctrl_q;
        2'd1:    rd_val = done_q;
        2'd2:    rd_val = err_q;
        default: rd_val = (DW'(rst_req_q) << HALF) | frz_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_val;
  end

  assign bus_rdata   = rdata_q;
  assign chan_freeze = frz_q[NCH-1:0];
  assign burst_en    = ctrl_q[BURST_BIT];
  assign burst8_en   = ctrl_q[BURST8_BIT];

  // ---------------- assertions ----------------
  AST_RST_PULSE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (($past(rst_req_set, 2) & ~chan_reset) == '0)); // R11

  AST_ERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    (err_q[NCH-1:0] != '0) |=> ((chan_irq & $past(err_q[NCH-1:0])) == $past(err_q[NCH-1:0]))); // R9

  AST_BUSERR_KIND: assert property (@(posedge clk) disable iff (rst)
    (evt_buserr != '0) |=> ((err_q[HALF +: NCH] & $past(evt_buserr)) == $past(evt_buserr))); // R7

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_v[3] == OP_NONE) |=> $stable(chan_freeze)); // R10
endmodule

// File: tb/dma_chan_regbank_bench.sv
module dma_chan_regbank_bench;
  localparam int NCH = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  evt_done = '0, evt_term = '0, evt_buserr = '0;
  logic [NCH-1:0]  chan_irq, chan_freeze, chan_reset;
  logic            burst_en, burst8_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_chan_regbank u_dma_chan_regbank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_done(evt_done),
    .evt_term(evt_term), .evt_buserr(evt_buserr), .chan_irq(chan_irq),
    .chan_freeze(chan_freeze), .chan_reset(chan_reset),
    .burst_en(burst_en), .burst8_en(burst8_en));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_evt(logic [NCH-1:0] dn, logic [NCH-1:0] tm, logic [NCH-1:0] be);
    @(negedge clk);
    evt_done = dn; evt_term = tm; evt_buserr = be;
    @(negedge clk);
    evt_done = '0; evt_term = '0; evt_buserr = '0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    for (int r = 0; r < 4; r++) begin
      bus_read(8'(r * 16), v);
      check("R1 register after reset", v, 32'h0);
    end
    check("R1 irq after reset", 32'(chan_irq), 32'h0);
    check("R1 freeze after reset", 32'(chan_freeze), 32'h0);
    check("R1 reset pulse after reset", 32'(chan_reset), 32'h0);
    check("R1 bursts after reset", {30'h0, burst8_en, burst_en}, 32'h0);
  endtask

  task automatic t_control();
    logic [31:0] v;
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_read(8'h00, v);
    check("R2 control writable bits", v, 32'h3000_0000);
    check("R13 both bursts on", {30'h0, burst8_en, burst_en}, 32'h3);
    bus_write(8'h08, 32'h1000_0000);
    bus_read(8'h00, v);
    check("R4 control clear alias", v, 32'h2000_0000);
    check("R13 burst off, burst8 on", {30'h0, burst8_en, burst_en}, 32'h2);
  endtask

  task automatic t_aliases();
    logic [31:0] v;
    bus_write(8'h10, 32'h1234_5678);
    bus_read(8'h10, v);
    check("R2 plain write", v, 32'h1234_5678);
    bus_read(8'h14, v);
    check("R12 read via set alias address", v, 32'h1234_5678);
    bus_write(8'h14, 32'h0100_0001);
    bus_read(8'h10, v);
    check("R3 set alias", v, 32'h1334_5679);
    bus_write(8'h18, 32'h0030_0070);
    bus_read(8'h18, v);
    check("R4 clear alias", v, 32'h1304_5609);
    bus_write(8'h10, 32'h0000_00FF);
    bus_read(8'h10, v);
    check("R2 plain replaces", v, 32'h0000_00FF);
    bus_read(8'h40, v);
    check("R12 unmapped reads zero", v, 32'h0);
    bus_read(8'h1C, v);
    check("R12 fourth alias reads zero", v, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    bus_write(8'h10, 32'h0);
    bus_write(8'h20, 32'h0);
    pulse_evt(16'h0008, 16'h0, 16'h0);
    bus_read(8'h10, v);
    check("R5 completion sets flag", v, 32'h0000_0008);
    check("R9 no irq without enable", 32'(chan_irq), 32'h0);
    bus_write(8'h14, 32'h0008_0000);
    @(negedge clk);
    check("R9 irq with enable", 32'(chan_irq), 32'h0008);
    pulse_evt(16'h0, 16'h0020, 16'h0);
    bus_read(8'h20, v);
    check("R6 termination error", v, 32'h0000_0020);
    check("R9 error irq", 32'(chan_irq), 32'h0028);
    pulse_evt(16'h0, 16'h0, 16'h0040);
    bus_read(8'h20, v);
    check("R7 bus error kind", v, 32'h0040_0060);
    pulse_evt(16'h0080, 16'h0080, 16'h0);
    bus_read(8'h20, v);
    check("R6 termination with completion no error", v, 32'h0040_0060);
    bus_read(8'h10, v);
    check("R5 completion with termination", v, 32'h0008_0088);
    bus_write(8'h28, 32'hFFFF_FFFF);
    bus_read(8'h20, v);
    check("R4 error clear", v, 32'h0);
    check("R9 irq after error clear", 32'(chan_irq), 32'h0008);
  endtask

  task automatic t_hw_wins();
    logic [31:0] v;
    bus_write(8'h10, 32'h0000_0003);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h0000_0003;
    evt_done = 16'h0001;
    @(negedge clk);
    bus_wr = 1'b0; evt_done = '0;
    bus_read(8'h10, v);
    check("R8 event beats clear", v, 32'h0000_0001);
  endtask

  task automatic t_freeze_reset();
    logic [31:0] v;
    bus_write(8'h34, 32'h0000_0005);
    check("R10 freeze set", 32'(chan_freeze), 32'h5);
    bus_write(8'h38, 32'h0000_0001);
    check("R10 freeze release", 32'(chan_freeze), 32'h4);
    bus_write(8'h34, 32'h0002_0000);
    check("R11 no pulse first cycle", 32'(chan_reset), 32'h0);
    @(negedge clk);
    check("R11 pulse second cycle", 32'(chan_reset), 32'h0002);
    @(negedge clk);
    check("R11 pulse one cycle only", 32'(chan_reset), 32'h0);
    bus_read(8'h30, v);
    check("R11 request self-cleared", v, 32'h0000_0004);
    bus_write(8'h38, 32'hFFFF_0000);
    for (int i = 0; i < 3; i++) begin
      check("R11 clear alias no pulse", 32'(chan_reset), 32'h0);
      @(negedge clk);
    end
    check("R10 freeze kept", 32'(chan_freeze), 32'h4);
    bus_write(8'h30, 32'h0001_0004);
    @(negedge clk);
    check("R11 plain write pulse", 32'(chan_reset), 32'h0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_control();
    t_aliases();
    t_events();
    t_hw_wins();
    t_freeze_reset();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule